// File: doc/BRIEF.md
# Interconnect performance counter unit

This block counts activity for one clock domain of an on-chip interconnect. It holds a small bank of 32-bit event counters and one 64-bit free-running cycle counter, all reached over a simple 32-bit register bus. Each event counter is tied to a single event source by a selector that holds the source's node type and node ID. Every cycle the interconnect offers at most one qualified event pulse, tagged with the type and ID of the node that raised it. Every event counter whose selector matches the tag and that is enabled counts the pulse.

Counter enables, interrupt enables and overflow flags are kept in three 32-bit masks. Each mask is changed only by write-one-to-set and write-one-to-clear accesses. Bit n of a mask (n below the number of event counters) belongs to event counter n, and bit 31 belongs to the cycle counter. A control register holds the global count enable and provides self-clearing strobes that zero the counters. The interrupt line to the host is raised whenever an overflow flag is set and its interrupt enable is also set.

Register writes take effect at the next clock edge. Read data is combinational from the current address.

Top module: `perf_counter_unit`

## Requirements
- R1: After reset, all counters, selectors, masks and the global enable are zero, and irq is low.
- R2: Event counter n is read and preloaded as a full 32-bit word at byte address 0x008 + 8*n. A preload in the same cycle as a counted event wins over the event.
- R3: The selector for counter n is at 0x400 + 4*n. Bits 12:9 hold the node type and bits 8:0 hold the node ID. All other bits are ignored on write and read as 0.
- R4: An event counter goes up by exactly one at the edge after a cycle in which all of these hold: ev_valid is high, {ev_node_type, ev_node_id} equals its selector, its enable bit is set, and the global enable is set. In any other cycle with no preload or reset it holds its value.
- R5: The 64-bit cycle counter reads its low word at 0x0F8 and its high word at 0x0FC, and both halves can be preloaded. It goes up by one every clock while the global enable and enable bit 31 are both set.
- R6: Writing ones at 0xC00 sets counter-enable bits, and writing ones at 0xC20 clears them. The mask reads back at both addresses. Only bits 0..NUM_EVT-1 and bit 31 exist; all other bits read 0.
- R7: Interrupt-enable bits are set by writing ones at 0xC40 and cleared by writing ones at 0xC60. They read back at both addresses and have the same live bits as in R6.
- R8: A counter wrapping from all ones to zero sets its overflow bit. Writing ones at 0xC80 clears overflow bits, and writing ones at 0xCC0 sets them. Both addresses read the overflow mask. When a set (from a wrap or from 0xCC0) and a clear hit the same bit in the same cycle, the bit ends up set.
- R9: The control register is at 0xE04. Bit 0 is the global enable and reads back. Writing 1 to bit 1 zeroes every event counter, and writing 1 to bit 2 zeroes the cycle counter. Bits 1 and 2 read 0. A reset strobe wins over a preload or a count in the same cycle.
- R10: irq is high exactly when some bit is set in both the overflow mask and the interrupt-enable mask.
- R11: Byte addresses not named in R2 to R9 or R12 read 0 and ignore writes.
- R12: The configuration word at 0xE00 reads 0x0040_0008 with the default parameters: bits 7:0 give the event counter count and bits 23:16 give the cycle counter width. Writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the monitored domain |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register bus |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| ev_valid | input | 1 | A qualified event pulse is present this cycle |
| ev_node_type | input | 4 | Node type of the event source |
| ev_node_id | input | 9 | Node ID of the event source |
| irq | output | 1 | Overflow interrupt to the host |

## Verification
Several properties are checked on every cycle:
- each counter steps by exactly one or holds according to its increment condition;
- a reset strobe leaves a counter at zero;
- a wrap always leaves its overflow flag set, even when a clear hits the same bit;
- a write-one clear drops only the bits that are not also being set;
- with the global enable off and no bus write, the cycle counter does not move.

Other behaviours can only be shown by the bench's scenarios against its own model. These are the address map and its holes, tag matching across selectors, preload-versus-count priority, the exact interrupt condition, and both halves of a 64-bit wrap.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
   localparam int BUS_W   = 32;
   localparam int CNT_W   = 32;
   localparam int CYC_W   = 64;
   localparam int TYPE_W  = 4;
   localparam int ID_W    = 9;
   localparam int SEL_W   = TYPE_W + ID_W;
   localparam int CYC_BIT = 31;

   localparam int A_EVT_BASE = 'h008;
   localparam int A_EVT_STEP = 8;
   localparam int A_CYC_LO   = 'h0F8;
   localparam int A_CYC_HI   = 'h0FC;
   localparam int A_SEL_BASE = 'h400;
   localparam int A_SEL_STEP = 4;
   localparam int A_EN_SET   = 'hC00;
   localparam int A_EN_CLR   = 'hC20;
   localparam int A_IE_SET   = 'hC40;
   localparam int A_IE_CLR   = 'hC60;
   localparam int A_OV_CLR   = 'hC80;
   localparam int A_OV_SET   = 'hCC0;
   localparam int A_CFG      = 'hE00;
   localparam int A_CTRL     = 'hE04;

   localparam int CTRL_GO      = 0;
   localparam int CTRL_ZAP_EVT = 1;
   localparam int CTRL_ZAP_CYC = 2;

   function automatic logic [BUS_W-1:0] live_mask(input int n_evt);
      logic [BUS_W-1:0] m;
      m = '0;
      for (int i = 0; i < n_evt; i++) m[i] = 1'b1;
      m[CYC_BIT] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/pcu_w1_mask.sv
module pcu_w1_mask
   import pcu_pkg::*;
#(
   parameter logic [BUS_W-1:0] LIVE = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BUS_W-1:0] set_bits,
   input  logic [BUS_W-1:0] clr_bits,
   output logic [BUS_W-1:0] q
);
   logic [BUS_W-1:0] nxt;

   // set has priority over clear on the same bit
   assign nxt = ((q & ~clr_bits) | set_bits) & LIVE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end

   p_set_sticks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_bits & LIVE) != '0) |=> ((q & $past(set_bits & LIVE)) == $past(set_bits & LIVE)));

   p_clear_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_bits & ~set_bits) != '0) |=> ((q & $past(clr_bits & ~set_bits)) == '0));
endmodule

// File: rtl/pcu_event_counter.sv
module pcu_event_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         zap,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         inc,
   output logic [W-1:0] cnt,
   output logic         wrap
);
   if (W < 2) begin : g_bad_w
      $error("pcu_event_counter: W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (zap)  cnt <= '0;
      else if (load) cnt <= load_val;
      else if (inc)  cnt <= cnt + 1'b1;
   end

   assign wrap = inc & ~zap & ~load & (&cnt);

   p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !zap && !load) |=> (cnt == $past(cnt) + 1'b1));

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !zap && !load) |=> $stable(cnt));

   p_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      zap |=> (cnt == '0));
endmodule

// File: rtl/pcu_cycle_counter.sv
module pcu_cycle_counter #(
   parameter int W     = 64,
   parameter int BUS_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             zap,
   input  logic             load_lo,
   input  logic             load_hi,
   input  logic [BUS_W-1:0] wdata,
   input  logic             inc,
   output logic [W-1:0]     cnt,
   output logic             wrap
);
   localparam int HI_W = W - BUS_W;

   if (W <= BUS_W || W > 2 * BUS_W) begin : g_bad_w
      $error("pcu_cycle_counter: W must lie in (BUS_W, 2*BUS_W]");
   end

   logic loading;
   assign loading = load_lo | load_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else if (zap) cnt <= '0;
      else if (loading) begin
         if (load_lo) cnt[BUS_W-1:0] <= wdata;
         if (load_hi) cnt[W-1:BUS_W] <= wdata[HI_W-1:0];
      end
      else if (inc) cnt <= cnt + 1'b1;
   end

   assign wrap = inc & ~zap & ~loading & (&cnt);

   p_cyc_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !zap && !loading) |=> (cnt == $past(cnt) + 1'b1));

   p_cyc_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      zap |=> (cnt == '0));
endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit
   import pcu_pkg::*;
#(
   parameter int NUM_EVT = 8,
   parameter int ADDR_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              ev_valid,
   input  logic [TYPE_W-1:0] ev_node_type,
   input  logic [ID_W-1:0]   ev_node_id,
   output logic              irq
);
   localparam logic [BUS_W-1:0] LIVE    = live_mask(NUM_EVT);
   localparam logic [BUS_W-1:0] CFG_VAL = BUS_W'((CYC_W << 16) | NUM_EVT);

   if (NUM_EVT < 1 || NUM_EVT > 30) begin : g_bad_count
      $error("perf_counter_unit: NUM_EVT must be 1..30");
   end
   if (ADDR_W < 12) begin : g_bad_addr
      $error("perf_counter_unit: ADDR_W must be at least 12");
   end

   logic                 gen_en_q;
   logic [SEL_W-1:0]     sel_q   [NUM_EVT];
   logic [CNT_W-1:0]     evt_cnt [NUM_EVT];
   logic [NUM_EVT-1:0]   evt_wrap;
   logic [CYC_W-1:0]     cyc_cnt;
   logic                 cyc_wrap;
   logic [BUS_W-1:0]     wrap_vec, cnt_en, int_en, ovf;
   logic [SEL_W-1:0]     ev_tag;

   // ---------------- write decode ----------------
   logic wr_ctrl, zap_evt, zap_cyc;
   logic wr_en_set, wr_en_clr, wr_ie_set, wr_ie_clr, wr_ov_set, wr_ov_clr;
   logic wr_cyc_lo, wr_cyc_hi;

   assign wr_ctrl   = reg_wr && (reg_addr == ADDR_W'(A_CTRL));
   assign zap_evt   = wr_ctrl && reg_wdata[CTRL_ZAP_EVT];
   assign zap_cyc   = wr_ctrl && reg_wdata[CTRL_ZAP_CYC];
   assign wr_en_set = reg_wr && (reg_addr == ADDR_W'(A_EN_SET));
   assign wr_en_clr = reg_wr && (reg_addr == ADDR_W'(A_EN_CLR));
   assign wr_ie_set = reg_wr && (reg_addr == ADDR_W'(A_IE_SET));
   assign wr_ie_clr = reg_wr && (reg_addr == ADDR_W'(A_IE_CLR));
   assign wr_ov_set = reg_wr && (reg_addr == ADDR_W'(A_OV_SET));
   assign wr_ov_clr = reg_wr && (reg_addr == ADDR_W'(A_OV_CLR));
   assign wr_cyc_lo = reg_wr && (reg_addr == ADDR_W'(A_CYC_LO));
   assign wr_cyc_hi = reg_wr && (reg_addr == ADDR_W'(A_CYC_HI));

   assign ev_tag = {ev_node_type, ev_node_id};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       gen_en_q <= 1'b0;
      else if (wr_ctrl) gen_en_q <= reg_wdata[CTRL_GO];
   end

   // ---------------- event counters ----------------
   for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
      localparam int A_CNT = A_EVT_BASE + A_EVT_STEP * i;
      localparam int A_SEL = A_SEL_BASE + A_SEL_STEP * i;
      logic ld_cnt, ld_sel, hit;

      assign ld_cnt = reg_wr && (reg_addr == ADDR_W'(A_CNT));
      assign ld_sel = reg_wr && (reg_addr == ADDR_W'(A_SEL));
      assign hit    = gen_en_q && cnt_en[i] && ev_valid && (ev_tag == sel_q[i]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      sel_q[i] <= '0;
         else if (ld_sel) sel_q[i] <= reg_wdata[SEL_W-1:0];
      end

      pcu_event_counter #(.W(CNT_W)) u_cnt (
         .clk      (clk),
         .rst_n    (rst_n),
         .zap      (zap_evt),
         .load     (ld_cnt),
         .load_val (reg_wdata),
         .inc      (hit),
         .cnt      (evt_cnt[i]),
         .wrap     (evt_wrap[i])
      );
   end

   // ---------------- cycle counter ----------------
   pcu_cycle_counter #(.W(CYC_W), .BUS_W(BUS_W)) u_cyc (
      .clk     (clk),
      .rst_n   (rst_n),
      .zap     (zap_cyc),
      .load_lo (wr_cyc_lo),
      .load_hi (wr_cyc_hi),
      .wdata   (reg_wdata),
      .inc     (gen_en_q && cnt_en[CYC_BIT]),
      .cnt     (cyc_cnt),
      .wrap    (cyc_wrap)
   );

   always_comb begin
      wrap_vec = '0;
      wrap_vec[NUM_EVT-1:0] = evt_wrap;
      wrap_vec[CYC_BIT] = cyc_wrap;
   end

   // ---------------- masks ----------------
   pcu_w1_mask #(.LIVE(LIVE)) u_en (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_bits (wr_en_set ? reg_wdata : '0),
      .clr_bits (wr_en_clr ? reg_wdata : '0),
      .q        (cnt_en)
   );

   pcu_w1_mask #(.LIVE(LIVE)) u_ie (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_bits (wr_ie_set ? reg_wdata : '0),
      .clr_bits (wr_ie_clr ? reg_wdata : '0),
      .q        (int_en)
   );

   pcu_w1_mask #(.LIVE(LIVE)) u_ov (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_bits ((wr_ov_set ? reg_wdata : '0) | wrap_vec),
      .clr_bits (wr_ov_clr ? reg_wdata : '0),
      .q        (ovf)
   );

   assign irq = |(ovf & int_en);

   // ---------------- read mux ----------------
   always_comb begin
      case (reg_addr)
         ADDR_W'(A_CYC_LO): reg_rdata = cyc_cnt[BUS_W-1:0];
         ADDR_W'(A_CYC_HI): reg_rdata = cyc_cnt[CYC_W-1:BUS_W];
         ADDR_W'(A_EN_SET),
         ADDR_W'(A_EN_CLR): reg_rdata = cnt_en;
         ADDR_W'(A_IE_SET),
         ADDR_W'(A_IE_CLR): reg_rdata = int_en;
         ADDR_W'(A_OV_SET),
         ADDR_W'(A_OV_CLR): reg_rdata = ovf;
         ADDR_W'(A_CFG):    reg_rdata = CFG_VAL;
         ADDR_W'(A_CTRL):   reg_rdata = {31'd0, gen_en_q};
         default:           reg_rdata = '0;
      endcase
      for (int i = 0; i < NUM_EVT; i++) begin
         if (reg_addr == ADDR_W'(A_EVT_BASE + A_EVT_STEP * i)) reg_rdata = evt_cnt[i];
         if (reg_addr == ADDR_W'(A_SEL_BASE + A_SEL_STEP * i)) reg_rdata = 32'(sel_q[i]);
      end
   end

   p_wrap_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_vec != '0) |=> ((ovf & $past(wrap_vec)) == $past(wrap_vec)));

   p_idle_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!gen_en_q && !reg_wr) |=> $stable(cyc_cnt));

   p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((ovf != '0) && (int_en != '0)));
endmodule

// File: tb/sim_perf_counter_unit.sv
module sim_perf_counter_unit;
   localparam int N = 8;
   localparam logic [31:0] LIVE = 32'h8000_00FF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        ev_valid = 1'b0;
   logic [3:0]  ev_node_type = '0;
   logic [8:0]  ev_node_id = '0;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   perf_counter_unit #(.NUM_EVT(N), .ADDR_W(12)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_valid(ev_valid),
      .ev_node_type(ev_node_type), .ev_node_id(ev_node_id), .irq(irq)
   );

   // ---------------- reference model ----------------
   logic [31:0] m_evt [N];
   logic [12:0] m_sel [N];
   logic [63:0] m_cyc;
   logic [31:0] m_en, m_ie, m_ov;
   logic        m_gen;

   function automatic logic [31:0] m_read(input logic [11:0] a);
      logic [31:0] r;
      r = 32'd0;
      for (int i = 0; i < N; i++) begin
         if (a == 12'(8 + 8 * i))       r = m_evt[i];
         if (a == 12'(12'h400 + 4 * i)) r = {19'd0, m_sel[i]};
      end
      case (a)
         12'h0F8: r = m_cyc[31:0];
         12'h0FC: r = m_cyc[63:32];
         12'hC00, 12'hC20: r = m_en;
         12'hC40, 12'hC60: r = m_ie;
         12'hC80, 12'hCC0: r = m_ov;
         12'hE00: r = 32'h0040_0008;
         12'hE04: r = {31'd0, m_gen};
         default: ;
      endcase
      return r;
   endfunction

   task automatic m_step(input logic wr, input logic [11:0] a, input logic [31:0] wd,
                         input logic vld, input logic [3:0] ty, input logic [8:0] id);
      logic [31:0] n_evt [N];
      logic [63:0] n_cyc;
      logic [31:0] wrapv;
      wrapv = 32'd0;
      for (int i = 0; i < N; i++) begin
         if (wr && a == 12'hE04 && wd[1])            n_evt[i] = 32'd0;
         else if (wr && a == 12'(8 + 8 * i))         n_evt[i] = wd;
         else if (m_gen && m_en[i] && vld && {ty, id} == m_sel[i]) begin
            n_evt[i] = m_evt[i] + 32'd1;
            if (m_evt[i] == 32'hFFFF_FFFF) wrapv[i] = 1'b1;
         end
         else n_evt[i] = m_evt[i];
      end
      n_cyc = m_cyc;
      if (wr && a == 12'hE04 && wd[2]) n_cyc = 64'd0;
      else if (wr && (a == 12'h0F8 || a == 12'h0FC)) begin
         if (a == 12'h0F8) n_cyc[31:0]  = wd;
         else              n_cyc[63:32] = wd;
      end
      else if (m_gen && m_en[31]) begin
         n_cyc = m_cyc + 64'd1;
         if (m_cyc == 64'hFFFF_FFFF_FFFF_FFFF) wrapv[31] = 1'b1;
      end
      for (int i = 0; i < N; i++) begin
         m_evt[i] = n_evt[i];
         if (wr && a == 12'(12'h400 + 4 * i)) m_sel[i] = wd[12:0];
      end
      m_cyc = n_cyc;
      if (wr && a == 12'hC00) m_en = m_en | (wd & LIVE);
      if (wr && a == 12'hC20) m_en = m_en & ~wd;
      if (wr && a == 12'hC40) m_ie = m_ie | (wd & LIVE);
      if (wr && a == 12'hC60) m_ie = m_ie & ~wd;
      m_ov = (m_ov & ~((wr && a == 12'hC80) ? wd : 32'd0))
           | ((wr && a == 12'hCC0) ? (wd & LIVE) : 32'd0) | wrapv;
      if (wr && a == 12'hE04) m_gen = wd[0];
   endtask

   // ---------------- drivers and checks ----------------
   task automatic cyc(input logic wr, input logic [11:0] a, input logic [31:0] wd,
                      input logic vld, input logic [3:0] ty, input logic [8:0] id,
                      output logic [31:0] rd);
      @(negedge clk);
      reg_wr = wr; reg_addr = a; reg_wdata = wd;
      ev_valid = vld; ev_node_type = ty; ev_node_id = id;
      #1;
      rd = reg_rdata;
      checks++;
      if (irq !== (|(m_ov & m_ie))) begin
         errors++;
         $display("FAIL R10 irq actual=%b expected=%b", irq, |(m_ov & m_ie));
      end
      @(posedge clk);
      m_step(wr, a, wd, vld, ty, id);
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] wd);
      logic [31:0] rd;
      cyc(1'b1, a, wd, 1'b0, 4'd0, 9'd0, rd);
   endtask

   task automatic ev(input logic [3:0] ty, input logic [8:0] id);
      logic [31:0] rd;
      cyc(1'b0, 12'h0, 32'd0, 1'b1, ty, id, rd);
   endtask

   task automatic vchk(input logic [11:0] a, input logic [31:0] expv, input string req);
      logic [31:0] rd;
      cyc(1'b0, a, 32'd0, 1'b0, 4'd0, 9'd0, rd);
      checks++;
      if (rd !== expv) begin
         errors++;
         $display("FAIL %s addr=%h actual=%h expected=%h", req, a, rd, expv);
      end
   endtask

   task automatic rchk(input logic [11:0] a, input string req);
      vchk(a, m_read(a), req);
   endtask

   task automatic irq_chk(input logic expv, input string req);
      checks++;
      if (irq !== expv) begin
         errors++;
         $display("FAIL %s irq actual=%b expected=%b", req, irq, expv);
      end
   endtask

   task automatic check_all(input string req);
      for (int i = 0; i < N; i++) rchk(12'(8 + 8 * i), req);
      for (int i = 0; i < N; i++) rchk(12'(12'h400 + 4 * i), req);
      rchk(12'h0F8, req); rchk(12'h0FC, req);
      rchk(12'hC00, req); rchk(12'hC40, req); rchk(12'hC80, req);
      rchk(12'hE04, req); rchk(12'hE00, req);
      rchk(12'h004, req); rchk(12'h100, req); rchk(12'hD00, req);
   endtask

   function automatic logic [11:0] pick_addr(input int s, input int k);
      case (s)
         0, 1, 2, 3, 17: return 12'(8 + 8 * (k % N));
         4, 5:  return 12'(12'h400 + 4 * (k % N));
         6:  return 12'h0F8;
         7:  return 12'h0FC;
         8:  return 12'hC00;
         9:  return 12'hC20;
         10: return 12'hC40;
         11: return 12'hC60;
         12: return 12'hC80;
         13: return 12'hCC0;
         14: return 12'hE04;
         15: return 12'hE00;
         default: begin
            case (k % 5)
               0: return 12'h004;
               1: return 12'h00C;
               2: return 12'h100;
               3: return 12'hD00;
               default: return 12'hFFC;
            endcase
         end
      endcase
   endfunction

   // ---------------- watchdog ----------------
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   // ---------------- main sequence ----------------
   initial begin
      logic [31:0] rd, expv, wd;
      logic [11:0] a;
      logic        w;
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < N; i++) begin m_evt[i] = '0; m_sel[i] = '0; end
      m_cyc = '0; m_en = '0; m_ie = '0; m_ov = '0; m_gen = 1'b0;

      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 / R12 reset state
      irq_chk(1'b0, "R1");
      vchk(12'h008, 32'd0, "R1");
      vchk(12'h0F8, 32'd0, "R1");
      vchk(12'hC00, 32'd0, "R1");
      vchk(12'hC80, 32'd0, "R1");
      vchk(12'hE04, 32'd0, "R1");
      check_all("R1");
      vchk(12'hE00, 32'h0040_0008, "R12");
      wr(12'hE00, 32'd0);
      vchk(12'hE00, 32'h0040_0008, "R12");

      // R3 selector fields, upper bits dropped
      wr(12'h400, 32'hFFFF_E000 | {19'd0, 4'h5, 9'h1A3});
      vchk(12'h400, {19'd0, 4'h5, 9'h1A3}, "R3");

      // R4 matching events only
      wr(12'hC00, 32'h1);
      wr(12'hE04, 32'h1);
      ev(4'h5, 9'h1A3); ev(4'h5, 9'h1A3); ev(4'h5, 9'h1A3);
      ev(4'h5, 9'h1A2); ev(4'h4, 9'h1A3);
      vchk(12'h008, 32'd3, "R4");
      vchk(12'h0F8, 32'd0, "R5");

      // R2 preload wins over event in the same cycle
      cyc(1'b1, 12'h008, 32'd100, 1'b1, 4'h5, 9'h1A3, rd);
      vchk(12'h008, 32'd100, "R2");

      // R8 wrap sets overflow even with same-cycle clear
      wr(12'h404, {19'd0, 4'h2, 9'h007});
      wr(12'h010, 32'hFFFF_FFFF);
      wr(12'hC40, 32'h2);
      wr(12'hC00, 32'h2);
      cyc(1'b1, 12'hC80, 32'h2, 1'b1, 4'h2, 9'h007, rd);
      vchk(12'h010, 32'd0, "R8");
      vchk(12'hC80, 32'h2, "R8");
      irq_chk(1'b1, "R10");
      wr(12'hC80, 32'h2);
      vchk(12'hCC0, 32'd0, "R8");
      irq_chk(1'b0, "R10");
      wr(12'hCC0, 32'hFFFF_FFFF);
      vchk(12'hC80, LIVE, "R8");
      irq_chk(1'b1, "R10");
      wr(12'hC80, 32'hFFFF_FFFF);
      vchk(12'hC80, 32'd0, "R8");

      // R5 64-bit cycle counter wrap
      wr(12'hE04, 32'h0);
      wr(12'h0F8, 32'hFFFF_FFFE);
      wr(12'h0FC, 32'hFFFF_FFFF);
      wr(12'hC00, 32'h8000_0000);
      wr(12'hE04, 32'h1);
      vchk(12'h0F8, 32'hFFFF_FFFE, "R5");
      vchk(12'h0FC, 32'hFFFF_FFFF, "R5");
      vchk(12'h0F8, 32'd0, "R5");
      vchk(12'h0FC, 32'd0, "R5");
      vchk(12'hC80, 32'h8000_0000, "R8");

      // R9 reset strobes
      wr(12'hE04, 32'h5);
      vchk(12'h0F8, 32'd0, "R9");
      vchk(12'hE04, 32'h1, "R9");
      vchk(12'h008, 32'd100, "R9");
      wr(12'hE04, 32'h3);
      vchk(12'h008, 32'd0, "R9");

      // R11 holes
      wr(12'h100, 32'hFFFF_FFFF);
      vchk(12'h100, 32'd0, "R11");
      wr(12'h00C, 32'hFFFF_FFFF);
      vchk(12'h00C, 32'd0, "R11");
      check_all("R11");

      // R6 / R7 live bits and paired addresses
      wr(12'hC00, 32'hFFFF_FFFF);
      vchk(12'hC20, LIVE, "R6");
      wr(12'hC20, 32'h1);
      vchk(12'hC00, LIVE & ~32'h1, "R6");
      wr(12'hC40, 32'hFFFF_FFFF);
      vchk(12'hC60, LIVE, "R7");
      wr(12'hC60, 32'hFFFF_FFFF);
      vchk(12'hC40, 32'd0, "R7");

      // random phase: every cycle reads and compares against the model
      for (int n = 0; n < 4000; n++) begin
         a = pick_addr(int'($urandom % 18), int'($urandom % 64));
         w = ($urandom % 3) == 0;
         wd = $urandom;
         if (a == 12'h0F8 || a == 12'h0FC || (a < 12'h0F8 && a[2:0] == 3'd0)) begin
            if ($urandom % 4 == 0) wd = 32'hFFFF_FFF0 | ($urandom % 16);
         end
         if (a >= 12'h400 && a < 12'h420)
            wd = ($urandom & 32'hFFFF_E000) | {19'd0, 4'($urandom % 4), 9'($urandom % 4)};
         if (a == 12'hE04)
            wd = {29'd0, ($urandom % 16) == 0, ($urandom % 16) == 0, ($urandom % 8) != 0};
         expv = m_read(a);
         cyc(w, a, wd, ($urandom % 4) != 0, 4'($urandom % 4), 9'($urandom % 4), rd);
         checks++;
         if (rd !== expv) begin
            errors++;
            $display("FAIL R4 random addr=%h actual=%h expected=%h", a, rd, expv);
         end
      end
      check_all("R2");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule